// File: doc/BRIEF.md
# SPI Master Burst Transfer Engine

This block shifts one burst of 8-bit frames out of an SPI master port. A control write that carries the start bit launches the burst. The burst length and the transmit length are given separately. Frames inside the transmit length take their data from a first-word-fall-through transmit FIFO. Frames past that length shift out zeros. Every received frame is pushed into a receive FIFO unless the discard bit was set when the burst started.

The serial clock advances only on an external enable tick, so the divider is kept outside the block. Four chip-select lines are driven in one of two modes. In automatic mode the selected line is asserted for the length of the burst. In manual mode software sets the selected line's level directly. In both modes the active-low bit fixes the level of the deselected lines. The end of a burst is marked by a one-cycle completion pulse, and the busy flag drops on the same clock.

Control word layout (`cfg`):
- bit 0: enable
- bit 1: master
- bit 2: clock phase
- bit 3: clock polarity
- bit 4: chip select active low
- bit 5: LSB first
- bit 6: start
- bits 8:7: chip-select index
- bit 9: receive discard
- bit 10: manual chip select
- bit 11: manual level

Top module: `spi_burst_engine`

## Requirements
- R1: A `cfg_we` write with bit 6 set starts a burst only when bits 0 and 1 are also set and no burst is running. `xch_busy` reads 1 from the next clock until the burst ends. Control writes made while busy are ignored entirely.
- R2: `burst_len` gives the total number of frames in the burst. A burst length of zero completes with no frame and no SCLK edge.
- R3: The first `tx_len` frames (never more than `burst_len`) each pop one byte from the transmit FIFO, in FIFO order. `txf_pop` is asserted only when the FIFO was not empty.
- R4: Frames after the transmit length is used up shift out 0x00 and pop nothing.
- R5: Each frame is 8 bits. The MSB goes first when bit 5 is 0 and the LSB goes first when bit 5 is 1, on both MOSI and MISO.
- R6: SCLK idles at the level of bit 3. With bit 2 = 0, MISO is sampled on the leading edge and MOSI changes on the trailing edge. With bit 2 = 1, MOSI changes on the leading edge and MISO is sampled on the trailing edge.
- R7: Each received frame is pushed into the receive FIFO, one push per frame. No push happens when bit 9 was set at start.
- R8: If the transmit FIFO is empty while transmit bytes remain, SCLK holds its idle level and the burst waits until data arrives.
- R9: `xfer_done` is a one-cycle pulse. `xch_busy` falls on the same clock edge.
- R10: In automatic mode (bit 10 = 0), the line picked by bits 8:7 is driven to the active level (low if bit 4 is set, high otherwise) while busy. Every other line, and the picked line when idle, sits at the inactive level.
- R11: In manual mode, the picked line follows bit 11 whether or not a burst runs. All other lines sit high if bit 4 is set and low if it is clear.
- R12: SCLK changes level during a burst only on clocks with `sclk_tick`. Each frame takes exactly 16 SCLK edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg | input | 12 | Control word, layout above |
| cfg_we | input | 1 | Control word write strobe |
| burst_len | input | 24 | Total frames in the burst |
| tx_len | input | 24 | Frames sourced from the transmit FIFO |
| sclk_tick | input | 1 | Half-period enable from the divider |
| txf_data | input | 8 | Transmit FIFO head byte |
| txf_empty | input | 1 | Transmit FIFO empty |
| txf_pop | output | 1 | Transmit FIFO pop |
| rxf_data | output | 8 | Received byte |
| rxf_push | output | 1 | Receive FIFO push |
| miso | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| spi_cs | output | 4 | Chip-select lines |
| xch_busy | output | 1 | Start bit readback, cleared at burst end |
| xfer_done | output | 1 | Burst complete pulse |

## Verification
The hardest state to reach is a burst that is stalled in mid-flight on an empty transmit FIFO. The bench starts a burst with nothing queued and holds it there for many cycles, checking that SCLK has not moved and that the busy flag is still set. Only then does it feed a byte and confirm the frame completes correctly.

A second hard case is a burst whose transmit length is shorter than its total length. Here the zero-fill frames must appear on MOSI after the FIFO bytes, while the pop count stops at the transmit length. A small slave model on the bench captures MOSI and drives MISO for each of the four clock modes and both bit orders.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  localparam int CFG_W  = 12;
  localparam int F_EN   = 0;
  localparam int F_MST  = 1;
  localparam int F_CPHA = 2;
  localparam int F_CPOL = 3;
  localparam int F_ALOW = 4;
  localparam int F_LSB  = 5;
  localparam int F_GO   = 6;
  localparam int F_SEL  = 7;
  localparam int F_DISC = 9;
  localparam int F_MAN  = 10;
  localparam int F_LVL  = 11;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_FETCH, SEQ_RUN, SEQ_END} seq_state_t;
endpackage

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] load_byte,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsb,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              active,
  output logic              frame_done,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int K_W   = $clog2(DATA_W);
  localparam int E_W   = K_W + 1;
  localparam logic [K_W-1:0] K_MAX = K_W'(DATA_W - 1);
  localparam logic [E_W-1:0] E_LAST = E_W'(2 * DATA_W - 1);

  logic              active_q, sclk_q, mosi_q, done_q, cpha_q, lsb_q;
  logic [E_W-1:0]    edge_q;
  logic [DATA_W-1:0] tx_q, rx_q, rxo_q;

  logic              leading, sample_now;
  logic [K_W-1:0]    k, drive_k, drive_pos, rx_pos;
  logic [DATA_W-1:0] rx_next;

  always_comb begin
    k          = edge_q[E_W-1:1];
    leading    = ~edge_q[0];
    sample_now = tick & active_q & (cpha_q ? ~leading : leading);
    rx_pos     = lsb_q ? k : K_MAX - k;
    drive_k    = cpha_q ? k : k + 1'b1;
    drive_pos  = lsb_q ? drive_k : K_MAX - drive_k;
    rx_next    = rx_q;
    if (sample_now) rx_next[rx_pos] = miso;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0; sclk_q <= 1'b0; mosi_q <= 1'b0; done_q <= 1'b0;
      cpha_q <= 1'b0; lsb_q <= 1'b0; edge_q <= '0;
      tx_q <= '0; rx_q <= '0; rxo_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        sclk_q <= cpol;
        if (load) begin
          active_q <= 1'b1;
          edge_q   <= '0;
          tx_q     <= load_byte;
          rx_q     <= '0;
          cpha_q   <= cpha;
          lsb_q    <= lsb;
          mosi_q   <= cpha ? 1'b0 : load_byte[lsb ? K_W'(0) : K_MAX];
        end
      end else if (tick) begin
        sclk_q <= ~sclk_q;
        edge_q <= edge_q + 1'b1;
        rx_q   <= rx_next;
        if (cpha_q ? leading : (!leading && k != K_MAX))
          mosi_q <= tx_q[drive_pos];
        if (edge_q == E_LAST) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
          rxo_q    <= rx_next;
        end
      end
    end
  end

  assign sclk       = sclk_q;
  assign mosi       = mosi_q;
  assign active     = active_q;
  assign frame_done = done_q;
  assign rx_byte    = rxo_q;
endmodule

// File: rtl/spi_cs_drive.sv
module spi_cs_drive #(
  parameter int NUM_CS = 4,
  parameter int SEL_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active_low,
  input  logic [SEL_W-1:0] sel,
  input  logic             manual,
  input  logic             level,
  input  logic             busy,
  output logic [NUM_CS-1:0] cs
);
  logic [NUM_CS-1:0] cs_q;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_line
    logic picked;
    assign picked = (sel == SEL_W'(i));
    always_ff @(posedge clk) begin
      if (rst)           cs_q[i] <= 1'b0;
      else if (!picked)  cs_q[i] <= active_low;
      else if (manual)   cs_q[i] <= level;
      else               cs_q[i] <= busy ? ~active_low : active_low;
    end
  end

  assign cs = cs_q;
endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
  import spi_burst_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 8,
  parameter int NUM_CS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CFG_W-1:0]  cfg,
  input  logic              cfg_we,
  input  logic [CNT_W-1:0]  burst_len,
  input  logic [CNT_W-1:0]  tx_len,
  input  logic              sclk_tick,
  input  logic [DATA_W-1:0] txf_data,
  input  logic              txf_empty,
  output logic              txf_pop,
  output logic [DATA_W-1:0] rxf_data,
  output logic              rxf_push,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic [NUM_CS-1:0] spi_cs,
  output logic              xch_busy,
  output logic              xfer_done
);
  localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

  seq_state_t        state;
  logic [CNT_W-1:0]  burst_left, tx_left;
  logic              cpha_q, cpol_q, lsb_q, alow_q, man_q, lvl_q, disc_q;
  logic [SEL_W-1:0]  sel_q;
  logic              xch_q, pop_q, push_q, tc_q;
  logic [DATA_W-1:0] push_data_q;

  logic              start_req, need_tx, load;
  logic [DATA_W-1:0] load_byte;
  logic              sh_active, sh_done;
  logic [DATA_W-1:0] sh_rx;

  assign start_req = cfg_we & cfg[F_GO] & cfg[F_EN] & cfg[F_MST] & (state == SEQ_IDLE);
  assign need_tx   = (tx_left != '0);
  assign load      = (state == SEQ_FETCH) && (burst_left != '0) && (!need_tx || !txf_empty);
  assign load_byte = need_tx ? txf_data : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SEQ_IDLE; burst_left <= '0; tx_left <= '0;
      cpha_q <= 1'b0; cpol_q <= 1'b0; lsb_q <= 1'b0; alow_q <= 1'b0;
      man_q <= 1'b0; lvl_q <= 1'b0; disc_q <= 1'b0; sel_q <= '0;
      xch_q <= 1'b0; pop_q <= 1'b0; push_q <= 1'b0; tc_q <= 1'b0;
      push_data_q <= '0;
    end else begin
      pop_q  <= 1'b0;
      push_q <= 1'b0;
      tc_q   <= 1'b0;
      if (cfg_we && state == SEQ_IDLE) begin
        cpha_q <= cfg[F_CPHA]; cpol_q <= cfg[F_CPOL]; lsb_q <= cfg[F_LSB];
        alow_q <= cfg[F_ALOW]; man_q <= cfg[F_MAN];  lvl_q <= cfg[F_LVL];
        sel_q  <= cfg[F_SEL +: SEL_W];
      end
      unique case (state)
        SEQ_IDLE: if (start_req) begin
          burst_left <= burst_len;
          tx_left    <= tx_len;
          disc_q     <= cfg[F_DISC];
          xch_q      <= 1'b1;
          state      <= SEQ_FETCH;
        end
        SEQ_FETCH: begin
          if (burst_left == '0) state <= SEQ_END;
          else if (load) begin
            burst_left <= burst_left - 1'b1;
            if (need_tx) begin
              tx_left <= tx_left - 1'b1;
              pop_q   <= 1'b1;
            end
            state <= SEQ_RUN;
          end
        end
        SEQ_RUN: if (sh_done) begin
          push_q      <= ~disc_q;
          push_data_q <= sh_rx;
          state       <= SEQ_FETCH;
        end
        SEQ_END: begin
          tc_q  <= 1'b1;
          xch_q <= 1'b0;
          state <= SEQ_IDLE;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  spi_frame_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .tick(sclk_tick), .load(load), .load_byte(load_byte),
    .cpol(cpol_q), .cpha(cpha_q), .lsb(lsb_q), .miso(miso),
    .sclk(sclk), .mosi(mosi), .active(sh_active), .frame_done(sh_done), .rx_byte(sh_rx)
  );

  spi_cs_drive #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_cs (
    .clk(clk), .rst(rst), .active_low(alow_q), .sel(sel_q), .manual(man_q),
    .level(lvl_q), .busy(state != SEQ_IDLE || sh_active), .cs(spi_cs)
  );

  assign txf_pop   = pop_q;
  assign rxf_push  = push_q;
  assign rxf_data  = push_data_q;
  assign xch_busy  = xch_q;
  assign xfer_done = tc_q;
endmodule

// File: rtl/spi_burst_engine_chk.sv
module spi_burst_engine_chk (
  input logic clk,
  input logic rst,
  input logic sclk,
  input logic sclk_tick,
  input logic xch_busy,
  input logic xfer_done,
  input logic txf_pop,
  input logic txf_empty,
  input logic rxf_push,
  input logic disc_q,
  input logic cpol_q
);
  // R9
  tc_single_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> !xfer_done);

  // R9
  busy_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(xch_busy) |-> xfer_done);

  // R3
  pop_guard_chk: assert property (@(posedge clk) disable iff (rst)
    txf_pop |-> $past(!txf_empty));

  // R7
  discard_chk: assert property (@(posedge clk) disable iff (rst)
    rxf_push |-> !disc_q);

  // R12
  tick_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (xch_busy && $past(xch_busy) && sclk != $past(sclk)) |-> $past(sclk_tick));

  // R6
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    (!xch_busy && $past(!xch_busy)) |-> sclk == $past(cpol_q));
endmodule

bind spi_burst_engine spi_burst_engine_chk u_chk (
  .clk(clk), .rst(rst), .sclk(sclk), .sclk_tick(sclk_tick), .xch_busy(xch_busy),
  .xfer_done(xfer_done), .txf_pop(txf_pop), .txf_empty(txf_empty),
  .rxf_push(rxf_push), .disc_q(disc_q), .cpol_q(cpol_q)
);

// File: tb/spi_burst_engine_bench.sv
module spi_burst_engine_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [11:0] cfg = '0;
  logic        cfg_we = 1'b0;
  logic [23:0] burst_len = '0, tx_len = '0;
  logic        sclk_tick = 1'b0;
  logic [7:0]  txf_data;
  logic        txf_empty, txf_pop;
  logic [7:0]  rxf_data;
  logic        rxf_push, miso, sclk, mosi, xch_busy, xfer_done;
  logic [3:0]  spi_cs;

  spi_burst_engine u_spi_burst_engine (
    .clk(clk), .rst(rst), .cfg(cfg), .cfg_we(cfg_we), .burst_len(burst_len),
    .tx_len(tx_len), .sclk_tick(sclk_tick), .txf_data(txf_data), .txf_empty(txf_empty),
    .txf_pop(txf_pop), .rxf_data(rxf_data), .rxf_push(rxf_push), .miso(miso),
    .sclk(sclk), .mosi(mosi), .spi_cs(spi_cs), .xch_busy(xch_busy), .xfer_done(xfer_done)
  );

  int n_chk = 0, n_fail = 0;

  // tick generator
  logic tick_en = 1'b1;
  int   tick_per = 2, tick_cnt = 0;
  always @(negedge clk) begin
    tick_cnt  = (tick_cnt + 1) % tick_per;
    sclk_tick <= tick_en && (tick_cnt == 0);
  end

  // transmit FIFO model, first word falls through
  logic [7:0] txq [0:15];
  int tx_wr = 0, tx_rd = 0, pop_cnt = 0;
  assign txf_empty = (tx_wr == tx_rd);
  assign txf_data  = txq[tx_rd % 16];
  always @(posedge clk) if (txf_pop) begin tx_rd <= tx_rd + 1; pop_cnt <= pop_cnt + 1; end

  // receive FIFO capture
  logic [7:0] rxq [0:127];
  int rx_n = 0;
  always @(posedge clk) if (rxf_push) begin rxq[rx_n] <= rxf_data; rx_n <= rx_n + 1; end

  // completion monitor
  int tc_cnt = 0, tc_busy_bad = 0, tc_wide_bad = 0;
  logic tc_prev = 1'b0;
  always @(negedge clk) begin
    if (xfer_done) begin
      tc_cnt++;
      if (xch_busy) tc_busy_bad++;
      if (tc_prev) tc_wide_bad++;
    end
    tc_prev = xfer_done;
  end

  // slave model
  logic b_cpha = 1'b0, b_lsb = 1'b0;
  logic [7:0] sb  [0:127];
  logic [7:0] cap [0:127];
  int ecnt = 0;
  always @(sclk) begin
    if (xch_busy) begin
      int e, f, k;
      e = ecnt % 16; f = ecnt / 16; k = e / 2;
      if (b_cpha ? (e % 2 == 1) : (e % 2 == 0))
        cap[f][b_lsb ? k : 7 - k] = mosi;
      ecnt = ecnt + 1;
    end
  end
  always_comb begin
    int rel, f, k;
    rel = ecnt;
    if (b_cpha && rel > 0) rel = rel - 1;
    f = rel / 16; k = (rel % 16) / 2;
    miso = b_lsb ? sb[f][k] : sb[f][7 - k];
  end

  // vectors: [20] cpol [19] cpha [18] lsb [17:16] cs index [15:8] tx byte [7:0] miso byte
  localparam logic [20:0] VEC [0:5] = '{
    {1'b0, 1'b0, 1'b0, 2'd0, 8'hA5, 8'h3C},
    {1'b0, 1'b1, 1'b0, 2'd1, 8'h81, 8'h7E},
    {1'b1, 1'b0, 1'b0, 2'd2, 8'h12, 8'hC4},
    {1'b1, 1'b1, 1'b0, 2'd3, 8'hF0, 8'h0F},
    {1'b0, 1'b0, 1'b1, 2'd1, 8'h01, 8'h80},
    {1'b1, 1'b1, 1'b1, 2'd2, 8'h6B, 8'hD2}
  };

  function automatic logic [11:0] mk(logic cpol, logic cpha, logic lsb, logic al,
                                     logic [1:0] idx, logic disc, logic man, logic lvl, logic go);
    mk = {lvl, man, disc, idx, go, lsb, al, cpol, cpha, 2'b11};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_tx(logic [7:0] b);
    txq[tx_wr % 16] = b;
    tx_wr = tx_wr + 1;
  endtask

  task automatic write_cfg(logic [11:0] w);
    @(negedge clk); cfg = w; cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  int pop_base, rx_base, e_base, tc_base;

  task automatic kick(logic cpol, logic cpha, logic lsb, logic al, logic [1:0] idx,
                      logic disc, int blen, int tlen);
    b_cpha = cpha; b_lsb = lsb;
    write_cfg(mk(cpol, cpha, lsb, al, idx, disc, 1'b0, 1'b0, 1'b0));
    repeat (3) @(negedge clk);
    pop_base = pop_cnt; rx_base = rx_n; e_base = ecnt; tc_base = tc_cnt;
    burst_len = 24'(blen); tx_len = 24'(tlen);
    write_cfg(mk(cpol, cpha, lsb, al, idx, disc, 1'b0, 1'b0, 1'b1));
  endtask

  task automatic wait_done(string req);
    int guard;
    guard = 0;
    while (tc_cnt == tc_base && guard < 20000) begin @(negedge clk); guard++; end
    chk(req, 32'(tc_cnt - tc_base), 32'd1);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) sb[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    chk("R1 reset busy", {31'd0, xch_busy}, 32'd0);
    chk("R6 reset sclk", {31'd0, sclk}, 32'd0);
    chk("R10 reset cs", {28'd0, spi_cs}, 32'd0);
    chk("R9 reset done", {31'd0, xfer_done}, 32'd0);

    // vector table: one frame per entry
    for (int i = 0; i < 6; i++) begin
      int fr;
      logic [20:0] v;
      v = VEC[i];
      fr = ecnt / 16;
      sb[fr] = v[7:0];
      push_tx(v[15:8]);
      kick(v[20], v[19], v[18], 1'b1, v[17:16], 1'b0, 1, 1);
      wait_done("R9 vector done");
      chk("R5 R6 mosi byte", {24'd0, cap[fr]}, {24'd0, v[15:8]});
      chk("R6 R7 miso byte", {24'd0, rxq[rx_base]}, {24'd0, v[7:0]});
      chk("R12 edges per frame", 32'(ecnt - e_base), 32'd16);
      chk("R6 sclk idle", {31'd0, sclk}, {31'd0, v[20]});
    end

    // burst longer than transmit count: zero fill
    begin
      int fr;
      fr = ecnt / 16;
      sb[fr] = 8'h11; sb[fr+1] = 8'h22; sb[fr+2] = 8'h33; sb[fr+3] = 8'h44;
      push_tx(8'hDE); push_tx(8'hAD);
      kick(1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 4, 2);
      wait_done("R2 burst done");
      chk("R3 first byte", {24'd0, cap[fr]}, 32'hDE);
      chk("R3 second byte", {24'd0, cap[fr+1]}, 32'hAD);
      chk("R4 zero fill a", {24'd0, cap[fr+2]}, 32'h00);
      chk("R4 zero fill b", {24'd0, cap[fr+3]}, 32'h00);
      chk("R3 R4 pop count", 32'(pop_cnt - pop_base), 32'd2);
      chk("R2 R7 rx count", 32'(rx_n - rx_base), 32'd4);
      chk("R7 rx last", {24'd0, rxq[rx_base+3]}, 32'h44);
      chk("R2 edge count", 32'(ecnt - e_base), 32'd64);
    end

    // receive discard
    push_tx(8'h5A);
    kick(1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 1'b1, 2, 1);
    wait_done("R7 discard done");
    chk("R7 discard no push", 32'(rx_n - rx_base), 32'd0);

    // zero-length burst
    kick(1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 0, 0);
    wait_done("R2 zero burst done");
    chk("R2 zero burst edges", 32'(ecnt - e_base), 32'd0);
    chk("R2 zero burst pops", 32'(pop_cnt - pop_base), 32'd0);

    // start refused without enable
    tc_base = tc_cnt;
    write_cfg(12'b0000_0100_0010);
    repeat (3) @(negedge clk);
    chk("R1 no start without enable", {31'd0, xch_busy}, 32'd0);
    chk("R1 no done without enable", 32'(tc_cnt - tc_base), 32'd0);

    // stall on empty transmit FIFO, then resume
    begin
      int fr;
      fr = ecnt / 16;
      sb[fr] = 8'h99;
      kick(1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1, 1);
      repeat (50) @(negedge clk);
      chk("R8 busy while starved", {31'd0, xch_busy}, 32'd1);
      chk("R8 no edges while starved", 32'(ecnt - e_base), 32'd0);
      chk("R8 sclk idle while starved", {31'd0, sclk}, 32'd0);
      push_tx(8'hC3);
      wait_done("R8 resume done");
      chk("R8 byte after stall", {24'd0, cap[fr]}, 32'hC3);
    end

    // tick gating and control writes ignored while busy
    tick_en = 1'b0;
    push_tx(8'h77);
    kick(1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0, 1, 1);
    repeat (4) @(negedge clk);
    chk("R10 auto cs active low", {28'd0, spi_cs}, 32'hB);
    write_cfg(mk(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0));
    repeat (40) @(negedge clk);
    chk("R12 no edge without tick", 32'(ecnt - e_base), 32'd0);
    chk("R1 write ignored while busy", {28'd0, spi_cs}, 32'hB);
    tick_en = 1'b1;
    wait_done("R12 gated done");
    chk("R12 frame edges", 32'(ecnt - e_base), 32'd16);
    chk("R1 cpol kept", {31'd0, sclk}, 32'd0);
    chk("R10 auto cs idle", {28'd0, spi_cs}, 32'hF);

    // automatic, active high
    tick_per = 8;
    push_tx(8'h42);
    kick(1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 1, 1);
    repeat (4) @(negedge clk);
    chk("R10 auto cs active high", {28'd0, spi_cs}, 32'h2);
    wait_done("R10 done");
    chk("R10 auto cs high idle", {28'd0, spi_cs}, 32'h0);
    tick_per = 2;

    // manual chip select
    write_cfg(mk(1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0));
    repeat (3) @(negedge clk);
    chk("R11 manual low", {28'd0, spi_cs}, 32'h7);
    write_cfg(mk(1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0));
    repeat (3) @(negedge clk);
    chk("R11 manual high", {28'd0, spi_cs}, 32'hF);
    write_cfg(mk(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0));
    repeat (3) @(negedge clk);
    chk("R11 manual active high idle low", {28'd0, spi_cs}, 32'h1);

    chk("R9 done with busy low", 32'(tc_busy_bad), 32'd0);
    chk("R9 done one cycle", 32'(tc_wide_bad), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule